// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block divides one 32-bit operand by another, either as two's-complement values or as unsigned values, and returns only the quotient. A caller presents both operands, a signedness select and a one-cycle `start_i` pulse while the unit is idle. A non-zero divisor runs a radix-2 restoring loop for one quotient bit per clock. When the loop ends the result appears together with a one-cycle `done_o` pulse. Signed results are formed on magnitudes and the sign is restored at the end, so the quotient truncates toward zero.

A zero divisor takes no iterations. The unit finishes on the next clock with a quotient of zero and sets its divide-by-zero status bit. It raises an exception request with a fixed cause code only when the caller's exception-enable input is high and the build-time trap option is on. Any accepted division with a non-zero divisor clears the status bit again, so the bit always describes the most recent accepted operation.

Top module: `int_div_trap`

## Requirements
- R1: In unsigned mode (`signed_i`=0) a non-zero divisor gives `quot_o` = floor(dividend / divisor) with both operands read as unsigned 32-bit numbers.
- R2: In signed mode (`signed_i`=1) both operands are two's-complement and the quotient truncates toward zero (for example -100 / 7 = -14, 100 / -7 = -14).
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF (-1) returns 0x80000000, with `exc_req_o`=0 and `dz_o`=0.
- R4: A zero divisor accepted at a clock edge gives `done_o`=1, `quot_o`=0 and `dz_o`=1 right after that edge, and `busy_o` is never raised.
- R5: `exc_req_o` pulses together with `done_o` for a zero divisor only when `exc_en_i` was 1 at acceptance and parameter `TRAP_EN` is non-zero; otherwise it stays 0.
- R6: While `exc_req_o` is 1, `exc_cause_o` equals 5'b00101; otherwise it is 0.
- R7: Accepting a division with a non-zero divisor clears `dz_o` from the next cycle on.
- R8: A non-zero division keeps `busy_o` high for exactly 32 cycles after the accepting edge. `done_o` rises as `busy_o` falls and stays high for one cycle.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The running division's result, `dz_o` and `exc_req_o` are unchanged by it.
- R10: After reset `busy_o`, `done_o`, `dz_o`, `exc_req_o` are 0 and `quot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division; taken only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| exc_en_i | input | 1 | Global exception enable, sampled at acceptance |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient of the last completed division |
| dz_o | output | 1 | Divide-by-zero status of the last accepted operation |
| exc_req_o | output | 1 | Exception request pulse |
| exc_cause_o | output | 5 | Cause code while `exc_req_o` is high |

## Verification
The bound checker checks the cycle-level protocol on every clock. A zero divisor must finish one edge later with a zero quotient and the status bit set. A blocked enable must suppress the request, and the cause code must match every request. A busy window must last exactly 32 cycles before `done_o` rises. The checker does not know quotient values. Only the bench's directed and random divisions show truncation toward zero, the most-negative-by-minus-one case, and that a start issued mid-run leaves the result alone.

// File: rtl/div_pkg.sv
package div_pkg;
    // Cause code reported with a zero-divisor exception request
    localparam logic [4:0] DIVZ_CAUSE = 5'b00101;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic [W-1:0] a_mag_o,
    output logic [W-1:0] b_mag_o,
    output logic         neg_o,
    output logic         b_zero_o
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg    = signed_i & a_i[W-1];
        b_neg    = signed_i & b_i[W-1];
        a_mag_o  = a_neg ? (~a_i + 1'b1) : a_i;
        b_mag_o  = b_neg ? (~b_i + 1'b1) : b_i;
        neg_o    = a_neg ^ b_neg;
        b_zero_o = (b_i == '0);
    end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        diff    = shifted - {1'b0, dsr_i};
        fits    = ~diff[W];
        rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] mag_i,
    input  logic         neg_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        res_o = neg_i ? (~mag_i + 1'b1) : mag_i;
    end
endmodule

// File: rtl/int_div_trap.sv
module int_div_trap #(
    parameter int W       = 32,
    parameter bit TRAP_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         exc_en_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic         dz_o,
    output logic         exc_req_o,
    output logic [4:0]   exc_cause_o
);
    import div_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dsr;
        logic          neg;
        logic          done;
        logic [W-1:0]  res;
        logic          dz;
        logic          exc;
    } div_state_t;

    div_state_t st_d, st_q;

    logic [W-1:0] a_mag, b_mag;
    logic         op_neg, b_zero;
    logic [W-1:0] step_rem, step_quo;
    logic [W-1:0] fixed_res;

    div_operand_prep #(.W(W)) u_prep (
        .a_i      (dividend_i),
        .b_i      (divisor_i),
        .signed_i (signed_i),
        .a_mag_o  (a_mag),
        .b_mag_o  (b_mag),
        .neg_o    (op_neg),
        .b_zero_o (b_zero)
    );

    div_restore_step #(.W(W)) u_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dsr_i (st_q.dsr),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    div_result_fix #(.W(W)) u_fix (
        .mag_i (step_quo),
        .neg_i (st_q.neg),
        .res_o (fixed_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.exc  = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                if (b_zero) begin
                    st_d.done = 1'b1;
                    st_d.res  = '0;
                    st_d.dz   = 1'b1;
                    st_d.exc  = exc_en_i && TRAP_EN;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                    st_d.rem  = '0;
                    st_d.quo  = a_mag;
                    st_d.dsr  = b_mag;
                    st_d.neg  = op_neg;
                    st_d.dz   = 1'b0;
                end
            end
        end else begin
            st_d.rem = step_rem;
            st_d.quo = step_quo;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = fixed_res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;
    assign quot_o      = st_q.res;
    assign dz_o        = st_q.dz;
    assign exc_req_o   = st_q.exc;
    assign exc_cause_o = st_q.exc ? DIVZ_CAUSE : 5'b0;
endmodule

// File: rtl/int_div_trap_chk.sv
module int_div_trap_chk #(
    parameter int W       = 32,
    parameter bit TRAP_EN = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] divisor_i,
    input logic         exc_en_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] quot_o,
    input logic         dz_o,
    input logic         exc_req_o,
    input logic [4:0]   exc_cause_o
);
    logic [$clog2(W+2)-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_cnt <= '0;
        else if (busy_o)  busy_cnt <= busy_cnt + 1'b1;
        else              busy_cnt <= '0;
    end

    // R4
    zero_div_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && divisor_i == '0) |=> (done_o && quot_o == '0 && dz_o && !busy_o));

    // R5
    exc_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (!exc_en_i || !TRAP_EN)) |=> !exc_req_o);

    // R5
    exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (done_o && dz_o));

    // R6
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (exc_cause_o == 5'b00101));

    // R6
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req_o |-> (exc_cause_o == 5'b0));

    // R7
    nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && divisor_i != '0) |=> (busy_o && !dz_o && !done_o));

    // R8
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && busy_cnt == ($clog2(W+2))'(W)));

    // R8
    no_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);
endmodule

bind int_div_trap int_div_trap_chk #(.W(W), .TRAP_EN(TRAP_EN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .divisor_i   (divisor_i),
    .exc_en_i    (exc_en_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quot_o      (quot_o),
    .dz_o        (dz_o),
    .exc_req_o   (exc_req_o),
    .exc_cause_o (exc_cause_o)
);

// File: tb/int_div_trap_tb.sv
module int_div_trap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn = 1'b0;
    logic [31:0] dvd = '0;
    logic [31:0] dvs = '0;
    logic        een = 1'b0;
    logic        busy, done, dz, exc;
    logic [31:0] quot;
    logic [4:0]  cause;
    logic        busy_nt, done_nt, dz_nt, exc_nt;
    logic [31:0] quot_nt;
    logic [4:0]  cause_nt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    int_div_trap u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
        .dividend_i(dvd), .divisor_i(dvs), .exc_en_i(een),
        .busy_o(busy), .done_o(done), .quot_o(quot), .dz_o(dz),
        .exc_req_o(exc), .exc_cause_o(cause)
    );

    int_div_trap #(.TRAP_EN(1'b0)) u_dut_notrap (
        .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
        .dividend_i(dvd), .divisor_i(dvs), .exc_en_i(een),
        .busy_o(busy_nt), .done_o(done_nt), .quot_o(quot_nt), .dz_o(dz_nt),
        .exc_req_o(exc_nt), .exc_cause_o(cause_nt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_quot(input logic [31:0] a, input logic [31:0] b, input logic s);
        longint sa, sb, q;
        if (b == 0) return 32'h0;
        if (!s) return a / b;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q  = sa / sb;
        return q[31:0];
    endfunction

    task automatic run_div(input logic [31:0] a, input logic [31:0] b, input logic s,
                           input logic en, input bit interfere, input string req);
        int lat;
        logic [31:0] eq;
        eq = ref_quot(a, b, s);
        @(negedge clk);
        start = 1'b1; dvd = a; dvs = b; sgn = s; een = en;
        @(negedge clk);
        start = 1'b0;
        chk(busy == (b != 0), {req, " R8 busy after accept"}, {31'b0, busy}, {31'b0, b != 0});
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (interfere && lat == 5) begin
                start = 1'b1; dvd = 32'h0000_1234; dvs = 32'h0; een = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(quot == eq, {req, " quotient"}, quot, eq);
        chk(lat == ((b != 0) ? 32 : 0), {req, " R8 latency"}, lat, (b != 0) ? 32 : 0);
        chk(dz == (b == 0), {req, " R4 R7 dz status"}, {31'b0, dz}, {31'b0, b == 0});
        chk(exc == (b == 0 && en), {req, " R5 exc request"}, {31'b0, exc}, {31'b0, b == 0 && en});
        chk(cause == ((b == 0 && en) ? 5'b00101 : 5'b0), {req, " R6 cause"}, {27'b0, cause},
            {27'b0, (b == 0 && en) ? 5'b00101 : 5'b0});
        chk(!exc_nt && done_nt && quot_nt == eq, {req, " R5 no-trap build"}, {31'b0, exc_nt}, 32'h0);
        @(negedge clk);
        chk(!done && !exc, {req, " R8 done one-cycle pulse"}, {30'b0, done, exc}, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R10
        chk(!busy && !done && !dz && !exc && quot == 0, "R10 reset state",
            {27'b0, busy, done, dz, exc, |quot}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_div(32'd100, 32'd7, 1'b0, 1'b1, 0, "R1 100/7");
        run_div(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 0, "R1 max/1");
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b1, 0, "R1 max/max-1");
        run_div(-32'sd100, 32'd7, 1'b1, 1'b1, 0, "R2 -100/7");
        run_div(32'd100, -32'sd7, 1'b1, 1'b1, 0, "R2 100/-7");
        run_div(-32'sd100, -32'sd7, 1'b1, 1'b1, 0, "R2 -100/-7");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 0, "R3 min/-1");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 0, "R1 unsigned min/-1");
        run_div(32'd5, 32'd0, 1'b0, 1'b1, 0, "R4 R5 R6 zero divisor enabled");
        run_div(32'd7, 32'd2, 1'b0, 1'b1, 0, "R7 clear after zero");
        run_div(32'd5, 32'd0, 1'b1, 1'b0, 0, "R5 zero divisor disabled");
        run_div(32'd3, 32'd9, 1'b1, 1'b0, 0, "R7 clear small");
        run_div(32'd1000, 32'd10, 1'b0, 1'b1, 1, "R9 start while busy");

        for (int i = 0; i < 40; i++) begin
            ra = $urandom;
            case ($urandom % 4)
                0:       rb = 32'h0;
                1:       rb = $urandom % 16;
                default: rb = $urandom;
            endcase
            run_div(ra, rb, 1'($urandom), 1'($urandom), 0, "R1 R2 R4 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule